// File: doc/BRIEF.md
# Radix-4 Booth Multiplier (signed or unsigned)

This block multiplies a multiplicand `a_in` by a multiplier `b_in` using modified (radix-4) Booth recoding. A single elaboration-time parameter, `SIGNED_MODE`, picks whether both operands are two's-complement numbers or plain unsigned numbers. The encoders, the decoder rows and the adder tree are the same in both modes. The mode changes only how the multiplier is padded above its top bit, how many encoders are built, how the extra top bit of each decoder row is formed, and how the short sign-extension tails on each row are derived.

Each encoder reads an overlapping three-bit window of the multiplier. Consecutive windows are two bits apart. From its window an encoder chooses a multiple of the multiplicand from {0, ±1, ±2}. A decoder row builds that multiple in one's-complement form, shifted left by twice the row index. Each row also carries a few tail bits, and these stand in for a full sign extension. A separate vector holds a +1 correction at the bottom of every negated row. All rows and the correction vector are compressed by a chain of carry-save adders into a sum and a carry. One carry-propagate adder adds these two. The result is captured in an output register that a synchronous active-high reset clears.

Top module: `booth_mult`

## Requirements
- R1: With `SIGNED_MODE`=0, one clock edge after `a_in` and `b_in` are sampled, `product` equals the unsigned product of the two operands, exact in `A_W+B_W` bits.
- R2: Each encoder reads its window (high, mid, low) and maps it as follows. 000 and 111 select zero. 001 and 010 select +1×. 011 selects +2×. 100 selects −2×. 101 and 110 select −1×. At most one of the 1× and 2× selects is active, and the negate control is active only when a nonzero multiple is selected.
- R3: With `SIGNED_MODE`=1, one clock edge after sampling, `product` equals the two's-complement product of the two signed operands, exact in `A_W+B_W` bits.
- R4: While `rst` is high at a rising edge, `product` becomes zero at that edge, whatever the operand values.
- R5: If either operand is zero, `product` is zero after the next edge, in both modes.
- R6: A multiplier of 1 yields the multiplicand widened to `A_W+B_W` bits. The widening uses zero fill when unsigned and copies of the multiplicand's top bit when signed.
- R7: The extreme operands give exact results. These are all-ones × all-ones when unsigned, and most-negative × most-negative, most-negative × largest-positive and largest-positive × largest-positive when signed.
- R8: Odd and unequal operand widths give exact products in both modes. The encoder count is `B_W/2+1` when unsigned and `(B_W+1)/2` when signed, using integer division.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the product register loads on the rising edge |
| rst | input | 1 | Synchronous active-high reset; clears the product register |
| a_in | input | A_W | Multiplicand |
| b_in | input | B_W | Multiplier; this operand is scanned by the Booth encoders |
| product | output | A_W+B_W | Registered product of the operands sampled at the previous edge |

## Verification
The bench builds four copies of the block, all fed from one stimulus stream. Two copies are 8×8, one signed and one unsigned. Because the 8-bit unsigned multiplier's last window ends exactly on its top bit, that copy needs the extra padded encoder. The other two copies have odd, unequal widths: a signed 7×5 and an unsigned 5×7. These reach the odd encoder counts, the sign-fill padding of a short multiplier, and tail bits that spill past the product width. Because the narrow copies take slices of the 8-bit operands, the stimulus is chosen so that their own most-negative and largest-positive values also appear.

// File: rtl/booth_mult_pkg.sv
`timescale 1ns/1ps
package booth_mult_pkg;

  // Control word produced by one Booth encoder.
  typedef struct packed {
    logic one;  // select 1x multiplicand
    logic two;  // select 2x multiplicand
    logic neg;  // negate the selected multiple
  } booth_ctl_t;

  // Number of encoders needed for a multiplier of width bw.
  // Unsigned operands need one extra window so the zero above the MSB is seen as positive.
  function automatic int enc_count(input int bw, input bit sgn);
    return sgn ? (bw + 1) / 2 : (bw / 2) + 1;
  endfunction

endpackage

// File: rtl/booth_encoder.sv
`timescale 1ns/1ps
module booth_encoder
  import booth_mult_pkg::*;
(
  input  logic [2:0]  trio,
  output booth_ctl_t  ctl
);

  always_comb begin
    ctl = '0;
    unique case (trio)
      3'b001, 3'b010: ctl.one = 1'b1;
      3'b011:         ctl.two = 1'b1;
      3'b100:         begin ctl.two = 1'b1; ctl.neg = 1'b1; end
      3'b101, 3'b110: begin ctl.one = 1'b1; ctl.neg = 1'b1; end
      default:        ctl = '0;   // 000 and 111 both select zero
    endcase
  end

endmodule

// File: rtl/booth_row.sv
`timescale 1ns/1ps
module booth_row
  import booth_mult_pkg::*;
#(
  parameter int A_W         = 8,
  parameter int P_W         = 16,
  parameter int ROW         = 0,
  parameter bit SIGNED_MODE = 1'b1
) (
  input  logic [A_W-1:0] x,
  input  booth_ctl_t     ctl,
  output logic [P_W-1:0] row_bits
);

  localparam int SHIFT = 2 * ROW;
  localparam int EXT_W = A_W + 4;  // body (A_W+1) plus three tail bits

  logic [A_W:0]    pick;
  logic [A_W:0]    body;
  logic            ext_sign;
  logic [2:0]      tail;
  logic [EXT_W-1:0] ext;

  // Low A_W bits: choose x[j] for 1x or x[j-1] for 2x.
  always_comb begin
    for (int j = 0; j < A_W; j++) begin
      if (j == 0) pick[j] = ctl.one & x[0];
      else        pick[j] = (ctl.one & x[j]) | (ctl.two & x[j-1]);
    end
  end

  // Top body bit and row sign depend on the operand mode.
  generate
    if (SIGNED_MODE) begin : g_sgn
      assign pick[A_W] = (ctl.one | ctl.two) & x[A_W-1];
      assign ext_sign  = ctl.neg ^ ((ctl.one | ctl.two) & x[A_W-1]);
    end else begin : g_uns
      assign pick[A_W] = ctl.two & x[A_W-1];
      assign ext_sign  = ctl.neg;
    end
  endgenerate

  assign body = pick ^ {(A_W+1){ctl.neg}};

  // Tails, listed from the top bit down. Summed over all rows their constants cancel
  // modulo 2^P_W.
  generate
    if (ROW == 0) begin : g_first
      assign tail = {~ext_sign, ext_sign, ext_sign};
    end else begin : g_rest
      assign tail = {1'b0, 1'b1, ~ext_sign};
    end
  endgenerate

  assign ext = {tail, body};

  always_comb begin
    row_bits = '0;
    for (int j = 0; j < P_W; j++) begin
      if (j >= SHIFT && (j - SHIFT) < EXT_W) row_bits[j] = ext[j - SHIFT];
    end
  end

endmodule

// File: rtl/booth_csa_tree.sv
`timescale 1ns/1ps
module booth_csa_tree #(
  parameter int P_W  = 16,
  parameter int N_IN = 5
) (
  input  logic [N_IN-1:0][P_W-1:0] terms,
  output logic [P_W-1:0]           sum_v,
  output logic [P_W-1:0]           carry_v
);

  logic [P_W-1:0] s_st [N_IN-1];
  logic [P_W-1:0] c_st [N_IN-1];

  assign s_st[0] = terms[0];
  assign c_st[0] = terms[1];

  // Linear carry-save array: each level folds one more term in.
  for (genvar k = 1; k < N_IN - 1; k++) begin : g_lvl
    assign s_st[k] = s_st[k-1] ^ c_st[k-1] ^ terms[k+1];
    assign c_st[k] = ((s_st[k-1] & c_st[k-1]) |
                      (s_st[k-1] & terms[k+1]) |
                      (c_st[k-1] & terms[k+1])) << 1;
  end

  assign sum_v   = s_st[N_IN-2];
  assign carry_v = c_st[N_IN-2];

endmodule

// File: rtl/booth_mult.sv
`timescale 1ns/1ps
module booth_mult
  import booth_mult_pkg::*;
#(
  parameter int A_W         = 8,
  parameter int B_W         = 8,
  parameter bit SIGNED_MODE = 1'b1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [A_W-1:0]     a_in,
  input  logic [B_W-1:0]     b_in,
  output logic [A_W+B_W-1:0] product
);

  localparam int P_W    = A_W + B_W;
  localparam int N_ENC  = enc_count(B_W, SIGNED_MODE);
  localparam int YP_W   = 2 * N_ENC + 1;

  logic [YP_W-1:0]         y_pad;
  logic                    y_fill;
  logic [N_ENC-1:0]        sel_one, sel_two, sel_neg;
  logic [N_ENC:0][P_W-1:0] terms;
  logic [P_W-1:0]          corr;
  logic [P_W-1:0]          csa_sum, csa_carry;

  assign y_fill = SIGNED_MODE ? b_in[B_W-1] : 1'b0;

  // Bit 0 is the implicit zero below the LSB; bits above the MSB take the fill value.
  always_comb begin
    for (int i = 0; i < YP_W; i++) begin
      if (i == 0)        y_pad[i] = 1'b0;
      else if (i <= B_W) y_pad[i] = b_in[i-1];
      else               y_pad[i] = y_fill;
    end
  end

  for (genvar k = 0; k < N_ENC; k++) begin : g_enc
    booth_ctl_t ctl;

    booth_encoder u_enc (
      .trio (y_pad[2*k+2 : 2*k]),
      .ctl  (ctl)
    );

    assign sel_one[k] = ctl.one;
    assign sel_two[k] = ctl.two;
    assign sel_neg[k] = ctl.neg;

    booth_row #(
      .A_W         (A_W),
      .P_W         (P_W),
      .ROW         (k),
      .SIGNED_MODE (SIGNED_MODE)
    ) u_row (
      .x        (a_in),
      .ctl      (ctl),
      .row_bits (terms[k])
    );
  end

  // +1 completion of each negated row, placed at that row's lowest weight.
  always_comb begin
    corr = '0;
    for (int k = 0; k < N_ENC; k++) begin
      if (2 * k < P_W) corr[2*k] = sel_neg[k];
    end
  end

  assign terms[N_ENC] = corr;

  booth_csa_tree #(
    .P_W  (P_W),
    .N_IN (N_ENC + 1)
  ) u_csa (
    .terms   (terms),
    .sum_v   (csa_sum),
    .carry_v (csa_carry)
  );

  always_ff @(posedge clk) begin
    if (rst) product <= '0;
    else     product <= csa_sum + csa_carry;
  end

endmodule

module booth_mult_chk #(
  parameter int A_W         = 8,
  parameter int B_W         = 8,
  parameter bit SIGNED_MODE = 1'b1,
  parameter int N_ENC       = 4
) (
  input logic               clk,
  input logic               rst,
  input logic [A_W-1:0]     a_in,
  input logic [B_W-1:0]     b_in,
  input logic [A_W+B_W-1:0] product,
  input logic [N_ENC-1:0]   one_v,
  input logic [N_ENC-1:0]   two_v,
  input logic [N_ENC-1:0]   neg_v
);

  localparam int P_W = A_W + B_W;

  logic [P_W-1:0] a_ext, b_ext, ref_p;
  logic           armed;

  assign a_ext = SIGNED_MODE ? {{B_W{a_in[A_W-1]}}, a_in} : {{B_W{1'b0}}, a_in};
  assign b_ext = SIGNED_MODE ? {{A_W{b_in[B_W-1]}}, b_in} : {{A_W{1'b0}}, b_in};
  assign ref_p = a_ext * b_ext;

  always_ff @(posedge clk) armed <= !rst;

  // R1 (unsigned) and R3 (signed): exact product one edge later.
  assert_exact_product_R1: assert property (@(posedge clk) disable iff (rst)
    armed |-> product == $past(ref_p));

  assert_reset_clear_R4: assert property (@(posedge clk)
    rst |=> product == '0);

  assert_zero_operand_R5: assert property (@(posedge clk) disable iff (rst)
    (armed && ($past(a_in) == '0 || $past(b_in) == '0)) |-> product == '0);

  assert_unit_multiplier_R6: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(b_in) == B_W'(1)) |-> product == $past(a_ext));

  for (genvar k = 0; k < N_ENC; k++) begin : g_enc_chk
    assert_enc_select_R2: assert property (@(posedge clk) disable iff (rst)
      $onehot0({one_v[k], two_v[k]}) && (!neg_v[k] || one_v[k] || two_v[k]));
  end

endmodule

bind booth_mult booth_mult_chk #(
  .A_W         (A_W),
  .B_W         (B_W),
  .SIGNED_MODE (SIGNED_MODE),
  .N_ENC       (N_ENC)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .a_in    (a_in),
  .b_in    (b_in),
  .product (product),
  .one_v   (sel_one),
  .two_v   (sel_two),
  .neg_v   (sel_neg)
);

// File: tb/tb_booth_mult.sv
`timescale 1ns/1ps
module tb_booth_mult;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] a_drv = '0;
  logic [7:0] b_drv = '0;

  logic [15:0] p_s8, p_u8;
  logic [11:0] p_s75, p_u57;

  int n_total = 0;
  int n_bad   = 0;
  bit finished = 1'b0;

  logic [15:0] q_s8[$];
  logic [15:0] q_u8[$];
  logic [11:0] q_s75[$];
  logic [11:0] q_u57[$];
  string       q_tag[$];

  always #2 clk = ~clk;  // 250 MHz

  booth_mult #(.A_W(8), .B_W(8), .SIGNED_MODE(1'b1)) dut (
    .clk(clk), .rst(rst), .a_in(a_drv), .b_in(b_drv), .product(p_s8));

  booth_mult #(.A_W(8), .B_W(8), .SIGNED_MODE(1'b0)) dut_u (
    .clk(clk), .rst(rst), .a_in(a_drv), .b_in(b_drv), .product(p_u8));

  booth_mult #(.A_W(7), .B_W(5), .SIGNED_MODE(1'b1)) dut_s75 (
    .clk(clk), .rst(rst), .a_in(a_drv[6:0]), .b_in(b_drv[4:0]), .product(p_s75));

  booth_mult #(.A_W(5), .B_W(7), .SIGNED_MODE(1'b0)) dut_u57 (
    .clk(clk), .rst(rst), .a_in(a_drv[4:0]), .b_in(b_drv[6:0]), .product(p_u57));

  function automatic logic [15:0] ref_s8(input logic [7:0] a, input logic [7:0] b);
    logic [15:0] ax, bx;
    ax = {{8{a[7]}}, a};
    bx = {{8{b[7]}}, b};
    return ax * bx;
  endfunction

  function automatic logic [15:0] ref_u8(input logic [7:0] a, input logic [7:0] b);
    logic [15:0] ax, bx;
    ax = {8'h00, a};
    bx = {8'h00, b};
    return ax * bx;
  endfunction

  function automatic logic [11:0] ref_s75(input logic [6:0] a, input logic [4:0] b);
    logic [11:0] ax, bx;
    ax = {{5{a[6]}}, a};
    bx = {{7{b[4]}}, b};
    return ax * bx;
  endfunction

  function automatic logic [11:0] ref_u57(input logic [4:0] a, input logic [6:0] b);
    logic [11:0] ax, bx;
    ax = {7'h00, a};
    bx = {5'h00, b};
    return ax * bx;
  endfunction

  // Driver: set operands at the falling edge, queue what the next rising edge must give.
  task automatic drive(input logic [7:0] a, input logic [7:0] b, input string tag);
    @(negedge clk);
    rst   = 1'b0;
    a_drv = a;
    b_drv = b;
    q_s8.push_back(ref_s8(a, b));
    q_u8.push_back(ref_u8(a, b));
    q_s75.push_back(ref_s75(a[6:0], b[4:0]));
    q_u57.push_back(ref_u57(a[4:0], b[6:0]));
    q_tag.push_back(tag);
  endtask

  // R4: reset with live operands must still clear every product.
  task automatic drive_reset(input logic [7:0] a, input logic [7:0] b);
    @(negedge clk);
    rst   = 1'b1;
    a_drv = a;
    b_drv = b;
    q_s8.push_back('0);
    q_u8.push_back('0);
    q_s75.push_back('0);
    q_u57.push_back('0);
    q_tag.push_back("R4 reset clears product");
  endtask

  task automatic check(input logic [15:0] act, input logic [15:0] exp,
                       input string tag, input string unit);
    n_total++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s [%s] act=%h exp=%h", tag, unit, act, exp);
    end
  endtask

  // Monitor: one result per cycle, compared one time unit after the rising edge.
  always @(posedge clk) begin
    #1;
    if (q_tag.size() > 0) begin
      string t;
      t = q_tag.pop_front();
      check(p_s8, q_s8.pop_front(), t, "signed 8x8 R3");
      check(p_u8, q_u8.pop_front(), t, "unsigned 8x8 R1");
      check({4'h0, p_s75}, {4'h0, q_s75.pop_front()}, t, "signed 7x5 R8");
      check({4'h0, p_u57}, {4'h0, q_u57.pop_front()}, t, "unsigned 5x7 R8");
    end
  end

  initial begin
    drive_reset(8'h5A, 8'h33);
    drive_reset(8'hFF, 8'h81);

    // R5: zero operands
    drive(8'h00, 8'h00, "R5 both zero");
    drive(8'hA7, 8'h00, "R5 zero multiplier");
    drive(8'h00, 8'hFF, "R5 zero multiplicand");
    drive(8'hE0, 8'hA0, "R5 zero in narrow slices");

    // R6: unit multiplier
    drive(8'h80, 8'h01, "R6 unit multiplier");
    drive(8'hFF, 8'h01, "R6 unit multiplier");
    drive(8'h35, 8'h01, "R6 unit multiplier");

    // R7: extreme operands (8-bit and narrow-slice extremes)
    drive(8'h80, 8'h80, "R7 most negative squared");
    drive(8'hFF, 8'hFF, "R7 all ones");
    drive(8'h7F, 8'h7F, "R7 largest positive squared");
    drive(8'h80, 8'h7F, "R7 most negative times largest");
    drive(8'h7F, 8'h80, "R7 largest times most negative");
    drive(8'hC0, 8'h10, "R7 narrow most negative");
    drive(8'hBF, 8'h0F, "R7 narrow largest positive");
    drive(8'h9F, 8'h7F, "R7 narrow all ones");

    // R2: multiplier patterns that hit every window code
    drive(8'hB3, 8'h55, "R2 window codes");
    drive(8'hB3, 8'hAA, "R2 window codes");
    drive(8'hB3, 8'hCC, "R2 window codes");
    drive(8'hB3, 8'h33, "R2 window codes");
    drive(8'hB3, 8'hF0, "R2 window codes");
    drive(8'hB3, 8'h0F, "R2 window codes");
    drive(8'hB3, 8'h92, "R2 window codes");
    drive(8'hB3, 8'h6D, "R2 window codes");

    // R1 R3 R8: random operands
    for (int i = 0; i < 200; i++) begin
      drive(8'($urandom), 8'($urandom), "R1 R3 R8 random");
    end

    // R4 mid-run, then recovery
    drive_reset(8'h7F, 8'h80);
    drive(8'h12, 8'h34, "R1 R3 after reset");
    for (int i = 0; i < 40; i++) begin
      drive(8'($urandom), 8'($urandom), "R1 R3 R8 random after reset");
    end

    @(negedge clk);
    wait (q_tag.size() == 0);
    #3;
    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", n_total, n_bad);
      $finish;
    end
  end

  initial begin
    #(100000 * 4);
    if (!finished) begin
      finished = 1'b1;
      n_total++;
      n_bad++;
      $display("FAIL R1 watchdog act=timeout exp=completion");
      $display("  test done: total=%0d bad=%0d", n_total, n_bad);
      $finish;
    end
  end

endmodule